// File: doc/BRIEF.md
# Dual-Output PWM Time Base Generator

This block makes two pulse-width-modulated outputs from one shared 16-bit time-base counter. Two prescalers in series divide the system clock to make the counter's tick. The first divides by a power of two. The second divides by one, or by an even number from two to fourteen. In up-count mode the counter climbs from zero to a programmable period and then wraps to zero. In freeze mode it holds its value.

Each output has its own compare value and its own pair of action rules. One rule applies when the counter arrives at zero. The other applies when the counter arrives at that output's compare value. Each rule can do nothing, drive the output low, drive it high, or toggle it. The period can be loaded at once, or held in a shadow register that is copied in when the counter wraps.

Software programs the block through a simple write port: a strobe, an address and a data word. The same port can load the counter directly. The running count is visible on an output port.

Top module: `dual_pwm_timebase`

## Requirements
- R1: The counter ticks once every 2^n * h clocks while running. Here n is the control field bits [2:0], and h is 1 when the field m in bits [5:3] is 0, otherwise 2*m. A write to the control register (address 0) or to the counter (address 4) restarts the prescale count, so the first tick comes n-and-m-divide clocks after that write.
- R2: With control bit 6 set (up mode), each tick raises the counter by one. A tick on which the counter is at or above the active period sets it to 0 instead. One full cycle therefore lasts (period+1) ticks.
- R3: With control bit 6 clear (freeze mode), the counter holds its value and no output changes.
- R4: A write to address 4 loads the counter in the following cycle. It does not apply any output action.
- R5: The period is written at address 1. With control bit 7 clear, the new value becomes active at once. With bit 7 set, the active period changes only on a tick that wraps the counter to zero.
- R6: When a tick brings the counter to 0, each output applies its zero rule. The rule is bits [1:0] of its rule register: address 5 for output A, address 6 for output B.
- R7: When a tick brings the counter to an output's compare value, that output applies its compare rule, bits [3:2] of its rule register. Output A compares against address 2 and output B against address 3, and the two are independent.
- R8: Rule encoding: 00 no action, 01 drive low, 10 drive high, 11 toggle.
- R9: When the zero event and a compare event come on the same tick, the compare rule wins unless it is 00, in which case the zero rule applies.
- R10: After reset the counter is 0, both outputs are low, the block is in freeze mode, and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period, 2/3 compare A/B, 4 counter, 5/6 rules A/B) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current time-base counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Some properties hold on every cycle, and assertions check them there. The prescaler never ticks in freeze mode and counts up steadily between ticks. The counter either steps by one or wraps to zero, and it takes a direct load in the next cycle. A shadowed period stays fixed except at a wrap. An output stays steady between ticks and follows the set, clear and toggle rules on each event.

Other behaviours need the bench's scenarios. The number of clocks per cycle must match each prescaler combination. A deferred period must only take hold after the current cycle finishes. Waveforms with both compares active must match an independent reference model. A compare at zero must override the zero rule.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // rule register layout: [3:2] compare rule, [1:0] zero rule
  typedef struct packed {
    act_e on_cmp;
    act_e on_zero;
  } act_rule_t;

  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_PERIOD = 1;
  localparam int unsigned ADR_CMP0   = 2;
  localparam int unsigned ADR_COUNT  = 4;
  localparam int unsigned ADR_RULE0  = 5;
  localparam int unsigned N_OUT      = 2;

  // second-stage divide: 1 for code 0, otherwise twice the code
  function automatic int unsigned stage2_div(input int unsigned m);
    return (m == 0) ? 1 : (m << 1);
  endfunction

  // total clocks per counter tick
  function automatic int unsigned total_div(input int unsigned n, input int unsigned m);
    return stage2_div(m) << n;
  endfunction

  // pick the rule that wins on one tick
  function automatic act_e act_pick(input act_rule_t r, input logic zev, input logic cev);
    if (cev && r.on_cmp != ACT_NONE) return r.on_cmp;
    if (zev)                         return r.on_zero;
    return ACT_NONE;
  endfunction

  function automatic logic act_apply(input act_e a, input logic cur);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TGL:  return ~cur;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_tb_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int PS_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] n_code,
  input  logic [CODE_W-1:0] m_code,
  output logic              tick
);

  logic [PS_W-1:0] div;
  logic [PS_W-1:0] pcnt;

  always_comb div = PS_W'(total_div(int'(n_code), int'(m_code)));

  assign tick = run && (pcnt == div - PS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (!run || restart)  pcnt <= '0;
    else if (tick)             pcnt <= '0;
    else                       pcnt <= pcnt + PS_W'(1);
  end

  // R3
  freeze_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  // R1
  presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> pcnt == $past(pcnt) + PS_W'(1));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             prd_wr,
  input  logic             shadow_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step,
  output logic             zero_ev
);

  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] prd_sh;
  logic             at_end;
  logic             wrap_step;

  assign at_end    = (cnt >= prd_act);
  assign cnt_nxt   = at_end ? '0 : cnt + CNT_W'(1);
  assign step      = tick && !cnt_wr;
  assign zero_ev   = step && (cnt_nxt == '0);
  assign wrap_step = step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= wdata;
    else if (tick)   cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= '0;
      prd_act <= '0;
    end else begin
      if (prd_wr) prd_sh <= wdata;
      if (prd_wr && !shadow_en)          prd_act <= wdata;
      else if (shadow_en && wrap_step)   prd_act <= prd_sh;
    end
  end

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt < prd_act) |=> cnt == $past(cnt) + CNT_W'(1));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt >= prd_act) |=> cnt == '0);

  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !(step && cnt >= prd_act)) |=> $stable(prd_act));

endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             zero_ev,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp,
  input  act_rule_t        rule,
  output logic             out
);

  logic cmp_ev;
  act_e act;

  assign cmp_ev = step && (cnt_nxt == cmp);
  assign act    = act_pick(rule, zero_ev, cmp_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else        out <= act_apply(act, out);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out));

  // R6
  zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_ev && !cmp_ev && rule.on_zero == ACT_HIGH) |=> out);

  // R7
  cmp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ev && rule.on_cmp == ACT_TGL) |=> out != $past(out));

  // R9
  cmp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ev && rule.on_cmp == ACT_LOW) |=> !out);

endmodule

// File: rtl/dual_pwm_timebase.sv
module dual_pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int MAX_N = (1 << CODE_W) - 1;
  localparam int PS_W  = MAX_N + $clog2(2 * MAX_N) + 1;
  localparam int RUN_B = 2 * CODE_W;
  localparam int SHD_B = 2 * CODE_W + 1;

  logic [CODE_W-1:0] n_code, m_code;
  logic              run, shadow_en;
  logic [CNT_W-1:0]  cmp  [N_OUT];
  act_rule_t         rule [N_OUT];
  logic [N_OUT-1:0]  outs;

  logic ctrl_wr, prd_wr, cnt_wr, tick, step, zero_ev;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign prd_wr  = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
  assign cnt_wr  = wr_en && (wr_addr == ADDR_W'(ADR_COUNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_code    <= '0;
      m_code    <= '0;
      run       <= 1'b0;
      shadow_en <= 1'b0;
    end else if (ctrl_wr) begin
      n_code    <= wr_data[CODE_W-1:0];
      m_code    <= wr_data[2*CODE_W-1:CODE_W];
      run       <= wr_data[RUN_B];
      shadow_en <= wr_data[SHD_B];
    end
  end

  pwm_prescale #(.CODE_W(CODE_W), .PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctrl_wr || cnt_wr),
    .n_code(n_code), .m_code(m_code), .tick(tick));

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .prd_wr(prd_wr),
    .shadow_en(shadow_en), .wdata(wr_data), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .step(step), .zero_ev(zero_ev));

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp[i]  <= '0;
        rule[i] <= act_rule_t'(4'b0000);
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(ADR_CMP0 + i))  cmp[i]  <= wr_data;
        if (wr_addr == ADDR_W'(ADR_RULE0 + i)) rule[i] <= act_rule_t'(wr_data[3:0]);
      end
    end

    pwm_action #(.CNT_W(CNT_W)) u_act (
      .clk(clk), .rst_n(rst_n), .step(step), .zero_ev(zero_ev),
      .cnt_nxt(cnt_nxt), .cmp(cmp[i]), .rule(rule[i]), .out(outs[i]));
  end

  assign count = cnt;
  assign pwm_a = outs[0];
  assign pwm_b = outs[1];

  // R3
  freeze_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));

endmodule

// File: tb/dual_pwm_timebase_tb.sv
module dual_pwm_timebase_tb;

  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [2:0]  n;
    logic [2:0]  m;
    logic        shd;
    logic [15:0] prd;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [15:0] per;   // expected clocks per full counter cycle
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 3'd0, 1'b0, 16'd9, 16'd3,  16'd7, 4'b0110, 4'b1110, 16'd10},
    '{3'd2, 3'd0, 1'b0, 16'd5, 16'd0,  16'd5, 4'b0110, 4'b1001, 16'd24},
    '{3'd1, 3'd3, 1'b0, 16'd3, 16'd2,  16'd9, 4'b1110, 4'b0110, 16'd48},
    '{3'd0, 3'd1, 1'b1, 16'd20, 16'd10, 16'd15, 4'b1111, 4'b0001, 16'd42},
    '{3'd7, 3'd7, 1'b0, 16'd1, 16'd1,  16'd0, 4'b0110, 4'b1110, 16'd3584},
    '{3'd3, 3'd2, 1'b0, 16'd2, 16'd1,  16'd2, 4'b1010, 4'b0111, 16'd96}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  wire  [15:0] count;
  wire         pwm_a, pwm_b;

  always #(CLK_NS/2) clk = ~clk;

  dual_pwm_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b));

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- reference model, written from the requirements ----------
  int          r_n, r_m, r_pc;
  bit          r_run, r_shd;
  logic [15:0] r_cnt, r_prd, r_prd_pend;
  logic [15:0] r_cmp [2];
  logic [3:0]  r_rule [2];
  logic        r_out [2];

  function automatic int ref_div(input int n, input int m);
    int h;
    h = (m == 0) ? 1 : m + m;
    return h * (1 << n);
  endfunction

  function automatic logic ref_act(input logic [1:0] code, input logic cur);
    if (code == 2'b01) return 1'b0;
    if (code == 2'b10) return 1'b1;
    if (code == 2'b11) return !cur;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_n = 0; r_m = 0; r_pc = 0; r_run = 0; r_shd = 0;
      r_cnt = 0; r_prd = 0; r_prd_pend = 0;
      for (int i = 0; i < 2; i++) begin r_cmp[i] = 0; r_rule[i] = 0; r_out[i] = 0; end
    end else begin
      bit tk, wcnt, wctl, wraps;
      logic [15:0] nx;
      tk   = r_run && (r_pc + 1 == ref_div(r_n, r_m));
      wcnt = wr_en && wr_addr == 3'd4;
      wctl = wr_en && wr_addr == 3'd0;
      wraps = r_cnt >= r_prd;
      nx   = wraps ? 16'd0 : r_cnt + 16'd1;
      if (tk && !wcnt) begin
        for (int i = 0; i < 2; i++) begin
          logic [1:0] ca, za;
          ca = r_rule[i][3:2]; za = r_rule[i][1:0];
          if (nx == r_cmp[i] && ca != 2'b00) r_out[i] = ref_act(ca, r_out[i]);
          else if (nx == 16'd0)              r_out[i] = ref_act(za, r_out[i]);
        end
        if (wraps && r_shd) r_prd = r_prd_pend;
      end
      if (wr_en && wr_addr == 3'd1) begin
        if (!r_shd) r_prd = wr_data;
        r_prd_pend = wr_data;
      end
      if (wcnt) r_cnt = wr_data;
      else if (tk) r_cnt = nx;
      if (!r_run || wcnt || wctl || tk) r_pc = 0;
      else r_pc = r_pc + 1;
      if (wr_en && wr_addr == 3'd2) r_cmp[0] = wr_data;
      if (wr_en && wr_addr == 3'd3) r_cmp[1] = wr_data;
      if (wr_en && wr_addr == 3'd5) r_rule[0] = wr_data[3:0];
      if (wr_en && wr_addr == 3'd6) r_rule[1] = wr_data[3:0];
      if (wctl) begin
        r_n = int'(wr_data[2:0]); r_m = int'(wr_data[5:3]);
        r_run = wr_data[6]; r_shd = wr_data[7];
      end
    end
  end

  // continuous comparison against the model (R2, R6, R7, R8)
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(count == r_cnt, "R2 count vs model", int'(count), int'(r_cnt));
      check(pwm_a == r_out[0], "R7 output A vs model", int'(pwm_a), int'(r_out[0]));
      check(pwm_b == r_out[1], "R7 output B vs model", int'(pwm_b), int'(r_out[1]));
    end
  end

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(count == 16'd0, "R10 count after reset", int'(count), 0);
    check(pwm_a == 1'b0, "R10 pwm_a after reset", int'(pwm_a), 0);
    check(pwm_b == 1'b0, "R10 pwm_b after reset", int'(pwm_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1;

    // vector table: R1 period in clocks, plus model comparison
    foreach (VECS[v]) begin
      int last, cyc, runlen;
      logic [15:0] prev;
      vec_t t;
      t = VECS[v];
      wr(0, 0);
      wr(1, int'(t.prd));
      wr(2, int'(t.ca));
      wr(3, int'(t.cb));
      wr(5, int'(t.ra));
      wr(6, int'(t.rb));
      wr(4, 0);
      wr(0, (int'(t.shd) << 7) | (1 << 6) | (int'(t.m) << 3) | int'(t.n));
      last = -1; cyc = 0; prev = count;
      runlen = 3 * int'(t.per) + 20;
      for (int k = 0; k < runlen; k++) begin
        @(negedge clk);
        cyc++;
        if (count == 16'd0 && prev != 16'd0) begin
          if (last >= 0)
            check(cyc - last == int'(t.per), "R1 clocks per cycle", cyc - last, int'(t.per));
          last = cyc;
        end
        prev = count;
      end
    end

    // R3: freeze holds the counter and outputs
    begin
      logic [15:0] held; logic ha, hb;
      wr(0, 16'h0000);
      held = count; ha = pwm_a; hb = pwm_b;
      repeat (25) @(negedge clk);
      check(count == held, "R3 frozen count", int'(count), int'(held));
      check(pwm_a == ha && pwm_b == hb, "R3 frozen outputs", int'({pwm_a, pwm_b}), int'({ha, hb}));
    end

    // R4: direct counter load, no action
    begin
      logic ha, hb;
      wr(5, 4'b1111); wr(6, 4'b1111); wr(2, 16'h1234);
      ha = pwm_a; hb = pwm_b;
      wr(4, 16'h1234);
      check(count == 16'h1234, "R4 direct load", int'(count), 'h1234);
      check(pwm_a == ha && pwm_b == hb, "R4 load applies no action", int'({pwm_a, pwm_b}), int'({ha, hb}));
    end

    // R5: shadowed period takes effect only at the wrap
    begin
      bit saw5; int mx;
      wr(0, 0); wr(1, 5); wr(4, 0);
      wr(0, (1 << 7) | (1 << 6));
      wr(1, 2);
      saw5 = 0;
      for (int k = 0; k < 20 && !(saw5 && count == 16'd0); k++) begin
        @(negedge clk);
        if (count == 16'd5) saw5 = 1;
      end
      check(saw5, "R5 old period finishes", int'(saw5), 1);
      mx = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (int'(count) > mx) mx = int'(count);
      end
      check(mx == 2, "R5 new period after wrap", mx, 2);
    end

    // R9: compare at zero overrides zero rule (zero high, compare low)
    begin
      wr(0, 0); wr(1, 3); wr(2, 0); wr(5, 4'b0110); wr(4, 1);
      wr(0, 1 << 6);
      for (int k = 0; k < 20 && count != 16'd3; k++) @(negedge clk);
      @(negedge clk);
      check(count == 16'd0, "R9 wrapped to zero", int'(count), 0);
      check(pwm_a == 1'b0, "R9 compare rule wins", int'(pwm_a), 0);
    end

    done = 1;
    summary();
  end

endmodule